// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two eight-bit buses, called A and B, and holds one storage register for each of them. Each side has separate input, output and output-enable signals, which replace three-state pins in a synthesizable design. A global enable, active low, and a direction input decide which side the block drives. When the global enable is high, neither side is driven. For each direction, a select input chooses the source of the driven data. The source is either the live value on the opposite bus (transparent) or the register captured from that bus (stored). The block always drives the bitwise inverse of the chosen source.

Each register has its own capture strobe. The strobes arrive as asynchronous level inputs. A synchronizer chain brings each strobe into the single system clock domain, and the matching bus data passes through a pipeline of the same depth. A rising strobe therefore stores the bus value that was present when the strobe was first sampled high. Capture always runs: the enable, direction and select inputs do not affect it. Use the block as a bus bridge that can either pass traffic straight through or replay a snapshot taken earlier.

Top module: `xrb_top`

## Requirements
- R1: While rst_ni is low, both registers are cleared to 8'h00. After release, a stored-mode read from either side returns 8'hFF, the inverse of zero.
- R2: A rising edge on cap_a_i stores the value a_in_i had on the first clock edge that sampled cap_a_i high. The new value drives the output from SYNC_STAGES+1 rising clock edges after that first sampling edge. Changes to a_in_i after that first sampling edge are not stored.
- R3: cap_b_i stores b_in_i into the B register under the same timing as R2. The two registers are independent: capturing into one never changes the other, and both may capture in the same cycle.
- R4: Capture takes place whatever the values of en_ni, dir_i, sel_a2b_i and sel_b2a_i, including while both sides are isolated.
- R5: While en_ni is 1, a_oe_o and b_oe_o are 0, and a_out_o and b_out_o are 8'h00.
- R6: With en_ni at 0, dir_i at 1 sets b_oe_o to 1 and a_oe_o to 0, and dir_i at 0 sets a_oe_o to 1 and b_oe_o to 0. A side that is not enabled outputs 8'h00.
- R7: When the B side is driven and sel_a2b_i is 0, b_out_o equals ~a_in_i in the same cycle. When the A side is driven and sel_b2a_i is 0, a_out_o equals ~b_in_i in the same cycle.
- R8: When the B side is driven and sel_a2b_i is 1, b_out_o equals the inverse of the A register.
- R9: When the A side is driven and sel_b2a_i is 1, a_out_o equals the inverse of the B register.
- R10: In stored mode, a capture in progress leaves the output at the old value up to the loading clock edge. From that edge on, the output shows the inverse of the newly captured value.
- R11: Holding a strobe high captures only once. Each new rising edge of the strobe captures again, so two short pulses in a row leave the register holding the second value.
- R12: a_oe_o and b_oe_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_in_i | input | 8 | Value present on the A bus |
| a_out_o | output | 8 | Data driven onto the A bus |
| a_oe_o | output | 1 | Drive enable for the A bus |
| b_in_i | input | 8 | Value present on the B bus |
| b_out_o | output | 8 | Data driven onto the B bus |
| b_oe_o | output | 1 | Drive enable for the B bus |
| cap_a_i | input | 1 | Capture strobe for the A register, asynchronous |
| cap_b_i | input | 1 | Capture strobe for the B register, asynchronous |
| sel_a2b_i | input | 1 | B-side source: 0 selects live A, 1 selects the A register |
| sel_b2a_i | input | 1 | A-side source: 0 selects live B, 1 selects the B register |
| dir_i | input | 1 | 1 drives B from A; 0 drives A from B |
| en_ni | input | 1 | Global enable, active low; 1 isolates both sides |

## Verification
A wrong register value is visible at the ports as soon as stored mode is selected in the matching direction, because the drive path is combinational and shows it in the same cycle. A misaligned synchronizer or data pipeline shows up as the wrong value being captured, or as the new value appearing one clock too early or too late around the loading edge. The bench samples on both sides of that edge. Wrong enable decoding shows in the same cycle as a wrong drive enable, or as non-zero data on a side that is not driven.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_LIVE   = 2'd1,
    SRC_STORED = 2'd2
  } src_e;
endpackage

// File: rtl/xrb_capture.sv
module xrb_capture #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] held_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0]            sync_q;
  logic [SYNC_STAGES-1:0][WIDTH-1:0] pipe_q;
  logic                              last_q;
  logic [WIDTH-1:0]                  held_q;
  logic                              load;

  assign load   = sync_q[LAST] & ~last_q;
  assign held_o = held_q;

  // data travels alongside the strobe so the captured word matches the sampling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      pipe_q <= '0;
      last_q <= 1'b0;
      held_q <= '0;
    end else begin
      sync_q[0] <= strobe_i;
      pipe_q[0] <= data_i;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
        pipe_q[i] <= pipe_q[i-1];
      end
      last_q <= sync_q[LAST];
      if (load) held_q <= pipe_q[LAST];
    end
  end

  // R2 / R3: a detected edge loads the aligned word
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> held_q == $past(pipe_q[LAST]));

  // R11: no edge, no change
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(held_q));
endmodule

// File: rtl/xrb_drive.sv
module xrb_drive
  import xrb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en_ni,
  input  logic             dir_i,
  input  logic             sel_a2b_i,
  input  logic             sel_b2a_i,
  input  logic [WIDTH-1:0] a_live_i,
  input  logic [WIDTH-1:0] b_live_i,
  input  logic [WIDTH-1:0] a_held_i,
  input  logic [WIDTH-1:0] b_held_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o
);
  src_e a_src, b_src;

  always_comb begin
    a_src = SRC_NONE;
    b_src = SRC_NONE;
    if (!en_ni) begin
      if (dir_i) b_src = sel_a2b_i ? SRC_STORED : SRC_LIVE;
      else       a_src = sel_b2a_i ? SRC_STORED : SRC_LIVE;
    end
  end

  always_comb begin
    unique case (a_src)
      SRC_LIVE:   a_out_o = ~b_live_i;
      SRC_STORED: a_out_o = ~b_held_i;
      default:    a_out_o = '0;
    endcase
    unique case (b_src)
      SRC_LIVE:   b_out_o = ~a_live_i;
      SRC_STORED: b_out_o = ~a_held_i;
      default:    b_out_o = '0;
    endcase
  end

  assign a_oe_o = (a_src != SRC_NONE);
  assign b_oe_o = (b_src != SRC_NONE);
endmodule

// File: rtl/xrb_top.sv
module xrb_top #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o,
  input  logic             cap_a_i,
  input  logic             cap_b_i,
  input  logic             sel_a2b_i,
  input  logic             sel_b2a_i,
  input  logic             dir_i,
  input  logic             en_ni
);
  localparam int NSIDES = 2;

  logic [NSIDES-1:0]            strobe;
  logic [NSIDES-1:0][WIDTH-1:0] bus_in;
  logic [NSIDES-1:0][WIDTH-1:0] held;

  assign strobe = {cap_b_i, cap_a_i};
  assign bus_in = {b_in_i, a_in_i};

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    xrb_capture #(
      .WIDTH      (WIDTH),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_cap (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(strobe[s]),
      .data_i  (bus_in[s]),
      .held_o  (held[s])
    );
  end

  xrb_drive #(.WIDTH(WIDTH)) u_drive (
    .en_ni    (en_ni),
    .dir_i    (dir_i),
    .sel_a2b_i(sel_a2b_i),
    .sel_b2a_i(sel_b2a_i),
    .a_live_i (a_in_i),
    .b_live_i (b_in_i),
    .a_held_i (held[0]),
    .b_held_i (held[1]),
    .a_out_o  (a_out_o),
    .a_oe_o   (a_oe_o),
    .b_out_o  (b_out_o),
    .b_oe_o   (b_oe_o)
  );

  assert_oe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  assert_isolate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |-> (!a_oe_o && !b_oe_o && a_out_o == '0 && b_out_o == '0));

  assert_dir_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_ni |-> (b_oe_o == dir_i && a_oe_o == !dir_i));

  assert_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !sel_a2b_i) |-> b_out_o == ~a_in_i);

  assert_stored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && sel_a2b_i) |-> b_out_o == ~held[0]);

  assert_stored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && sel_b2a_i) |-> a_out_o == ~held[1]);
endmodule

// File: tb/xrb_top_test.sv
module xrb_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SYNC       = 2;
  // stim {en_ni,dir,sel_a2b,sel_b2a} | exp {a_oe,b_oe,a_stored,b_stored}
  localparam logic [7:0] VEC [16] = '{
    8'b0000_1000, 8'b0001_1010, 8'b0010_1000, 8'b0011_1010,
    8'b0100_0100, 8'b0101_0100, 8'b0110_0101, 8'b0111_0101,
    8'b1000_0000, 8'b1001_0000, 8'b1010_0000, 8'b1011_0000,
    8'b1100_0000, 8'b1101_0000, 8'b1110_0000, 8'b1111_0000};

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic [W-1:0] a_in_i = '0, b_in_i = '0, a_out_o, b_out_o;
  logic         a_oe_o, b_oe_o;
  logic         cap_a_i = 1'b0, cap_b_i = 1'b0;
  logic         sel_a2b_i = 1'b0, sel_b2a_i = 1'b0, dir_i = 1'b0, en_ni = 1'b1;
  int           checks = 0, fails = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xrb_top #(.WIDTH(W), .SYNC_STAGES(SYNC)) uut (
    .clk_i, .rst_ni, .a_in_i, .a_out_o, .a_oe_o, .b_in_i, .b_out_o, .b_oe_o,
    .cap_a_i, .cap_b_i, .sel_a2b_i, .sel_b2a_i, .dir_i, .en_ni);

  task automatic check(string tag, logic [17:0] got, logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [17:0] obs();
    return {a_oe_o, a_out_o, b_oe_o, b_out_o};
  endfunction

  task automatic mode(logic en, logic dir, logic sab, logic sba);
    en_ni = en; dir_i = dir; sel_a2b_i = sab; sel_b2a_i = sba;
  endtask

  // strobe held SYNC+2 cycles; bus value changed after the first sampling edge
  task automatic capture(bit side_b, logic [W-1:0] d);
    @(negedge clk_i);
    if (side_b) begin b_in_i = d; cap_b_i = 1'b1; end
    else        begin a_in_i = d; cap_a_i = 1'b1; end
    @(negedge clk_i);
    if (side_b) b_in_i = ~d; else a_in_i = ~d;
    repeat (SYNC + 1) @(negedge clk_i);
    cap_a_i = 1'b0; cap_b_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] reg_a, reg_b;
    repeat (3) @(negedge clk_i);
    #1 check("R5 isolated in reset", obs(), 18'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1: registers zero after reset
    mode(0, 1, 1, 1); #1 check("R1 A reg zero", obs(), {1'b0, 8'h00, 1'b1, 8'hFF});
    mode(0, 0, 1, 1); #1 check("R1 B reg zero", obs(), {1'b1, 8'hFF, 1'b0, 8'h00});

    // R4: capture while isolated; R2/R3 alignment via capture task
    mode(1, 0, 0, 0);
    capture(0, 8'h3C);
    mode(1, 1, 1, 0);
    capture(1, 8'hA5);
    reg_a = 8'h3C; reg_b = 8'hA5;
    mode(0, 1, 1, 1); #1 check("R4 R2 A captured while isolated", obs(), {1'b0, 8'h00, 1'b1, ~reg_a});
    mode(0, 0, 1, 1); #1 check("R4 R3 B captured while isolated", obs(), {1'b1, ~reg_b, 1'b0, 8'h00});

    // R5..R9: every enable/direction/select combination
    a_in_i = 8'h5A; b_in_i = 8'hC3;
    for (int i = 0; i < 16; i++) begin
      logic [17:0] exp;
      @(negedge clk_i);
      mode(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      #1;
      exp[17]    = VEC[i][3];
      exp[16:9]  = VEC[i][3] ? ~(VEC[i][1] ? reg_b : b_in_i) : 8'h00;
      exp[8]     = VEC[i][2];
      exp[7:0]   = VEC[i][2] ? ~(VEC[i][0] ? reg_a : a_in_i) : 8'h00;
      check($sformatf("R5 R6 R7 R8 R9 R12 vector %0d", i), obs(), exp);
    end

    // R7: live path follows input in the same cycle
    mode(0, 1, 0, 0); a_in_i = 8'h0F; #1 check("R7 live A->B", obs(), {1'b0, 8'h00, 1'b1, 8'hF0});
    mode(0, 0, 0, 0); b_in_i = 8'h81; #1 check("R7 live B->A", obs(), {1'b1, 8'h7E, 1'b0, 8'h00});

    // R10: stored output switches exactly at the loading edge
    mode(0, 1, 1, 0);
    @(negedge clk_i); a_in_i = 8'h81; cap_a_i = 1'b1;
    @(negedge clk_i); a_in_i = 8'h00;
    @(negedge clk_i); #1 check("R10 old value before load edge", obs(), {1'b0, 8'h00, 1'b1, ~reg_a});
    @(negedge clk_i); #1 check("R10 new value after load edge", obs(), {1'b0, 8'h00, 1'b1, 8'h7E});
    reg_a = 8'h81;
    // R11: strobe still high, bus changes are not stored
    a_in_i = 8'h99;
    repeat (4) @(negedge clk_i);
    #1 check("R11 held strobe captures once", obs(), {1'b0, 8'h00, 1'b1, ~reg_a});
    cap_a_i = 1'b0;
    mode(0, 0, 0, 1); #1 check("R3 B untouched by A capture", obs(), {1'b1, ~reg_b, 1'b0, 8'h00});

    // R3: simultaneous capture on both sides
    @(negedge clk_i); a_in_i = 8'h11; b_in_i = 8'h22; cap_a_i = 1'b1; cap_b_i = 1'b1;
    @(negedge clk_i); a_in_i = 8'hEE; b_in_i = 8'hDD;
    repeat (SYNC + 1) @(negedge clk_i);
    cap_a_i = 1'b0; cap_b_i = 1'b0;
    mode(0, 1, 1, 1); #1 check("R2 A in joint capture", obs(), {1'b0, 8'h00, 1'b1, 8'hEE});
    mode(0, 0, 1, 1); #1 check("R3 B in joint capture", obs(), {1'b1, 8'hDD, 1'b0, 8'h00});

    // R11: back-to-back one-cycle pulses, second value wins
    mode(0, 1, 1, 0);
    @(negedge clk_i); a_in_i = 8'h44; cap_a_i = 1'b1;
    @(negedge clk_i); cap_a_i = 1'b0; a_in_i = 8'h00;
    @(negedge clk_i); a_in_i = 8'h55; cap_a_i = 1'b1;
    @(negedge clk_i); cap_a_i = 1'b0; a_in_i = 8'h00;
    @(negedge clk_i); #1 check("R11 first pulse loaded", obs(), {1'b0, 8'h00, 1'b1, 8'hBB});
    @(negedge clk_i);
    @(negedge clk_i); #1 check("R11 second pulse loaded", obs(), {1'b0, 8'h00, 1'b1, 8'hAA});

    // R1: reset mid-run clears both
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    #1 check("R1 A cleared by reset", obs(), {1'b0, 8'h00, 1'b1, 8'hFF});

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule